// File: doc/BRIEF.md
# Destructive-Read Memory Cycle Controller

This block runs the timing of read and write cycles against a coincident-current storage array whose read operation destroys the stored word. The host issues a request with a valid/acknowledge handshake. The controller latches a 15-bit address and keeps one data-buffer bit per storage plane. It then steps through a fixed sequence of phases: an inhibit-enable setup phase, a read drive pulse, a short gap, a write drive pulse, and a one-cycle done phase that raises the acknowledge. All phase lengths are counted in ticks of 0.1 µs. A clock prescaler derives each tick from a whole number of clock cycles.

During the read pulse, a narrow strobe window opens a fixed number of ticks after the pulse begins. Sense outputs are captured into the data buffer only while the strobe is high. Every read is followed by a restore write of the captured word to the same address, so the word survives the destructive read. A host write reuses the same sequence. Its read phase clears the addressed word and its sensed value is thrown away. The write phase then stores the host word. Because a write pulse can only set bits to 1, each plane whose buffer bit is 0 has its inhibit line asserted during the write pulse.

Top module: `dro_cycle_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes idle: busy, ack, rdata_valid, addr_en, rd_drive, wr_drive, strobe and inh_en are 0, and drive_addr and inhibit are all zeros.
- R2: When req_valid is high at an edge while idle, the request is accepted. From the next cycle there are SETUP_TICKS ticks of setup, PULSE_TICKS ticks of read drive, GAP_TICKS ticks of gap, PULSE_TICKS ticks of write drive, then one done cycle. With the defaults (TICK_DIV=4, 1/20/2/20 ticks), rd_drive is high in cycles 5–84 after the accepting edge, wr_drive in cycles 93–172, and ack in cycle 173.
- R3: strobe rises STB_DELAY ticks after rd_drive rises and stays high for STB_TICKS ticks. With the defaults this is read cycles 12–19, which is cycles 17–24 after the accepting edge.
- R4: For a read, the data buffer is cleared when the request is accepted. At each edge where strobe is high, the sense bits are ORed into it. Sense values outside the strobe window have no effect.
- R5: For a read, the write phase restores the captured word to the same address. rdata holds that word while rdata_valid is high.
- R6: For a write (req_write=1), the buffer takes req_wdata at acceptance and sense data is ignored. The word stored at the address after the cycle equals req_wdata.
- R7: inhibit[i] equals the inverse of data-buffer bit i while wr_drive is high, and is 0 at all other times.
- R8: inh_en is high from the first setup cycle through the last write cycle, so it rises before any drive pulse.
- R9: addr_en is high exactly when rd_drive or wr_drive is high. rd_drive and wr_drive are never high together. drive_addr equals the latched req_addr while addr_en is high and is zero otherwise.
- R10: busy is high from the cycle after acceptance through the ack cycle. Requests that arrive while busy is high are ignored and leave no pending cycle.
- R11: ack is high for exactly one cycle per accepted request. rdata_valid is high only in that cycle, and only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = host write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | PLANES | Word to write |
| busy | output | 1 | Cycle in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata_valid | output | 1 | rdata valid (reads only) |
| rdata | output | PLANES | Data buffer contents |
| sense | input | PLANES | Per-plane sense amplifier outputs |
| drive_addr | output | ADDR_W | Address to line decode, gated by addr_en |
| addr_en | output | 1 | Address translation enable |
| rd_drive | output | 1 | Read drive pulse |
| wr_drive | output | 1 | Write drive pulse |
| strobe | output | 1 | Sense capture window |
| inh_en | output | 1 | Inhibit enable |
| inhibit | output | PLANES | Per-plane inhibit lines |

## Verification
The bench puts a small core-array model at the sense and drive pins. This model clears a word when a read pulse starts and drives all-ones noise on the sense lines during the read pulse except inside the expected strobe window. A design that captured outside the window would therefore return ones when reading a zero word. A design that skipped the restore would read zeros on the second read of the same address. A design that skipped the clearing read on host writes would OR old and new data together, and overwriting a word with zeros exposes this. Further directed cases inject a request partway through a cycle to catch a design that queues requests or restarts. They also apply reset during a read pulse, which must drop every drive line at once.

// File: rtl/dro_pkg.sv
// Package: shared phase encoding for the destructive-read cycle controller.
// Assumes nothing beyond a single clock domain.
package dro_pkg;

    // Phases of one memory cycle; the order is the run order of a cycle.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_READ  = 3'd2,
        PH_GAP   = 3'd3,
        PH_WRITE = 3'd4,
        PH_DONE  = 3'd5
    } phase_t;

    // Phase that follows a timed phase once its tick budget is spent.
    function automatic phase_t next_timed_phase(input phase_t cur);
        case (cur)
            PH_SETUP: return PH_READ;
            PH_READ:  return PH_GAP;
            PH_GAP:   return PH_WRITE;
            PH_WRITE: return PH_DONE;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dro_tick_gen.sv
// Module: dro_tick_gen
// Emits a one-cycle tick every TICK_DIV clocks, so that one tick is 0.1 us.
// Assumes clr is held while idle, so that the first tick of a cycle comes
// exactly TICK_DIV clocks after acceptance.
module dro_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    generate
        if (TICK_DIV == 1) begin : g_every_clock
            // Every clock is a tick; clr has nothing to align.
            logic unused_clr;
            assign unused_clr = clr;
            assign tick = 1'b1;
        end else begin : g_prescale
            logic [CW-1:0] cnt_q;

            // Count clocks within the current tick and wrap at the last one.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/dro_phase_seq.sv
// Module: dro_phase_seq
// Phase sequencer: accepts a request while idle and steps through setup,
// read, gap, write and done. Each timed phase lasts a fixed number of ticks.
// It also decodes the strobe window from the tick count within the read phase.
// Assumes STB_DELAY + STB_TICKS <= PULSE_TICKS and that all lengths are >= 1.
module dro_phase_seq
    import dro_pkg::*;
#(
    parameter int SETUP_TICKS = 1,
    parameter int PULSE_TICKS = 20,
    parameter int GAP_TICKS   = 2,
    parameter int STB_DELAY   = 3,
    parameter int STB_TICKS   = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   tick,
    output phase_t phase,
    output logic   accept,
    output logic   strobe,
    output logic   tick_clr
);

    localparam int STB_END = STB_DELAY + STB_TICKS;
    localparam int MAX_A   = (SETUP_TICKS > GAP_TICKS) ? SETUP_TICKS : GAP_TICKS;
    localparam int MAX_B   = (PULSE_TICKS > STB_END) ? PULSE_TICKS : STB_END;
    localparam int MAXT    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW      = $clog2(MAXT + 1);

    localparam logic [TW-1:0] SETUP_LAST = TW'(SETUP_TICKS - 1);
    localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_TICKS - 1);
    localparam logic [TW-1:0] GAP_LAST   = TW'(GAP_TICKS - 1);
    localparam logic [TW-1:0] STB_LO     = TW'(STB_DELAY);
    localparam logic [TW-1:0] STB_HI     = TW'(STB_END);

    phase_t        phase_q;
    logic [TW-1:0] tcnt_q;
    logic [TW-1:0] last_tick;
    logic          phase_end;

    // Select the index of the final tick of the current timed phase.
    always_comb begin
        case (phase_q)
            PH_SETUP:          last_tick = SETUP_LAST;
            PH_READ, PH_WRITE: last_tick = PULSE_LAST;
            PH_GAP:            last_tick = GAP_LAST;
            default:           last_tick = '0;
        endcase
    end

    assign phase_end = tick && (tcnt_q == last_tick);
    assign accept    = (phase_q == PH_IDLE) && req_valid;

    // Advance the phase and the tick count within it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tcnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    tcnt_q <= '0;
                    if (req_valid) begin
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP, PH_READ, PH_GAP, PH_WRITE: begin
                    if (phase_end) begin
                        phase_q <= next_timed_phase(phase_q);
                        tcnt_q  <= '0;
                    end else if (tick) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    tcnt_q  <= '0;
                end
            endcase
        end
    end

    assign phase    = phase_q;
    assign tick_clr = (phase_q == PH_IDLE);
    assign strobe   = (phase_q == PH_READ) && (tcnt_q >= STB_LO) && (tcnt_q < STB_HI);

endmodule

// File: rtl/dro_word_path.sv
// Module: dro_word_path
// Address register, data buffer and per-plane inhibit drive. The buffer is
// loaded with the host word for a write and cleared for a read. During a read
// it ORs in the sense bits on strobe edges. Inhibit follows the zeros of the
// buffer during the write pulse.
// Assumes accept is a single-cycle pulse that occurs only while idle.
module dro_word_path #(
    parameter int ADDR_W = 15,
    parameter int PLANES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PLANES-1:0] req_wdata,
    input  logic              strobe,
    input  logic [PLANES-1:0] sense,
    input  logic              wr_phase,
    input  logic              line_en,
    output logic [ADDR_W-1:0] drive_addr,
    output logic [PLANES-1:0] rdata,
    output logic [PLANES-1:0] inhibit,
    output logic              op_write
);

    logic [ADDR_W-1:0] addr_q;
    logic [PLANES-1:0] buf_q;
    logic              op_write_q;

    // Latch the address and the operation kind when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            op_write_q <= 1'b0;
        end else if (accept) begin
            addr_q     <= req_addr;
            op_write_q <= req_write;
        end
    end

    // Data buffer: host word or cleared at accept; sense ORed in under strobe on reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (accept) begin
            buf_q <= req_write ? req_wdata : '0;
        end else if (strobe && !op_write_q) begin
            buf_q <= buf_q | sense;
        end
    end

    // One inhibit driver per plane, live only during the write pulse.
    generate
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            assign inhibit[p] = wr_phase & ~buf_q[p];
        end
    endgenerate

    assign drive_addr = line_en ? addr_q : '0;
    assign rdata      = buf_q;
    assign op_write   = op_write_q;

endmodule

// File: rtl/dro_cycle_ctrl.sv
// Module: dro_cycle_ctrl (top)
// Cycle controller for a destructive-readout storage array. Every request runs
// setup, read, gap, write and done. A read restores its captured word. A write
// first clears the word by reading it, then stores the host word under inhibit.
// Assumes sense is valid inside the strobe window. One tick is TICK_DIV clocks,
// which is 0.1 us.
module dro_cycle_ctrl
    import dro_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PLANES      = 16,
    parameter int TICK_DIV    = 4,
    parameter int SETUP_TICKS = 1,
    parameter int PULSE_TICKS = 20,
    parameter int GAP_TICKS   = 2,
    parameter int STB_DELAY   = 3,
    parameter int STB_TICKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PLANES-1:0] req_wdata,
    output logic              busy,
    output logic              ack,
    output logic              rdata_valid,
    output logic [PLANES-1:0] rdata,
    input  logic [PLANES-1:0] sense,
    output logic [ADDR_W-1:0] drive_addr,
    output logic              addr_en,
    output logic              rd_drive,
    output logic              wr_drive,
    output logic              strobe,
    output logic              inh_en,
    output logic [PLANES-1:0] inhibit
);

    phase_t phase;
    logic   tick;
    logic   tick_clr;
    logic   accept;
    logic   op_write;

    dro_tick_gen #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .tick (tick)
    );

    dro_phase_seq #(
        .SETUP_TICKS(SETUP_TICKS),
        .PULSE_TICKS(PULSE_TICKS),
        .GAP_TICKS  (GAP_TICKS),
        .STB_DELAY  (STB_DELAY),
        .STB_TICKS  (STB_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .tick     (tick),
        .phase    (phase),
        .accept   (accept),
        .strobe   (strobe),
        .tick_clr (tick_clr)
    );

    // Drive and handshake outputs decoded straight from the phase register.
    always_comb begin
        rd_drive = (phase == PH_READ);
        wr_drive = (phase == PH_WRITE);
        addr_en  = rd_drive | wr_drive;
        inh_en   = (phase == PH_SETUP) || (phase == PH_READ) ||
                   (phase == PH_GAP)   || (phase == PH_WRITE);
        busy     = (phase != PH_IDLE);
        ack      = (phase == PH_DONE);
    end

    dro_word_path #(
        .ADDR_W(ADDR_W),
        .PLANES(PLANES)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .strobe    (strobe),
        .sense     (sense),
        .wr_phase  (wr_drive),
        .line_en   (addr_en),
        .drive_addr(drive_addr),
        .rdata     (rdata),
        .inhibit   (inhibit),
        .op_write  (op_write)
    );

    assign rdata_valid = ack & ~op_write;

endmodule

// File: rtl/dro_cycle_ctrl_chk.sv
// Module: dro_cycle_ctrl_chk
// Property checker for dro_cycle_ctrl, attached by bind. It observes ports only.
module dro_cycle_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int PLANES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ack,
    input logic              rdata_valid,
    input logic [PLANES-1:0] rdata,
    input logic [ADDR_W-1:0] drive_addr,
    input logic              addr_en,
    input logic              rd_drive,
    input logic              wr_drive,
    input logic              strobe,
    input logic              inh_en,
    input logic [PLANES-1:0] inhibit
);

    // R7: no plane is inhibited outside the write pulse.
    a_r7_inhibit_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_drive |-> (inhibit == '0));

    // R9: address enable matches the drive pulses, which never overlap.
    a_r9_addr_en_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en == (rd_drive || wr_drive));
    a_r9_drives_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_drive, wr_drive}) <= 1);
    a_r9_addr_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en |-> (drive_addr == '0));
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en && $past(addr_en)) |-> $stable(drive_addr));

    // R3: the strobe lies within the read pulse.
    a_r3_strobe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> rd_drive);

    // R4: during a read pulse the buffer changes only after a strobe edge.
    a_r4_no_capture_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive && $past(rd_drive) && !$past(strobe)) |-> $stable(rdata));

    // R8: inhibit enable is up whenever a drive pulse is.
    a_r8_inh_en_covers_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive || wr_drive) |-> inh_en);
    a_r8_setup_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_drive) |-> $past(inh_en));

    // R10: busy holds until the ack cycle.
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> busy);

    // R11: ack is a single pulse that follows the write pulse; read data valid only with ack.
    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r11_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(wr_drive));
    a_r11_rdv_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> ack);

endmodule

bind dro_cycle_ctrl dro_cycle_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .PLANES(PLANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .ack        (ack),
    .rdata_valid(rdata_valid),
    .rdata      (rdata),
    .drive_addr (drive_addr),
    .addr_en    (addr_en),
    .rd_drive   (rd_drive),
    .wr_drive   (wr_drive),
    .strobe     (strobe),
    .inh_en     (inh_en),
    .inhibit    (inhibit)
);

// File: tb/dro_cycle_ctrl_tb.sv
// Bench for dro_cycle_ctrl, using default parameters and a behavioural core array.
module dro_cycle_ctrl_tb;

    localparam int ADDR_W = 15;
    localparam int PLANES = 16;
    localparam logic [10:0] AHI = 11'h5A3;

    // Vector format: {write, addr[3:0], data[15:0]}; data is the host word or the expected read word.
    localparam logic [20:0] VEC [10] = '{
        21'h11A5C3, 21'h12FFFF, 21'h01A5C3, 21'h01A5C3, 21'h110000,
        21'h010000, 21'h02FFFF, 21'h130001, 21'h030001, 21'h040000
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PLANES-1:0] req_wdata = '0;
    logic              busy, ack, rdata_valid, addr_en, rd_drive, wr_drive, strobe, inh_en;
    logic [PLANES-1:0] rdata, inhibit;
    logic [PLANES-1:0] sense = '0;
    logic [ADDR_W-1:0] drive_addr;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dro_cycle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ack(ack),
        .rdata_valid(rdata_valid), .rdata(rdata), .sense(sense),
        .drive_addr(drive_addr), .addr_en(addr_en), .rd_drive(rd_drive),
        .wr_drive(wr_drive), .strobe(strobe), .inh_en(inh_en), .inhibit(inhibit)
    );

    // Core array model: a read pulse wipes the word; sense shows it only in cycles 12..19 of the pulse, all ones elsewhere.
    logic [PLANES-1:0] mem [16];
    logic [PLANES-1:0] held;
    int rc = 0;
    initial for (int i = 0; i < 16; i++) mem[i] = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            rc = 0;
            sense <= '0;
        end else begin
            if (rd_drive) begin
                if (rc == 0) begin
                    held = mem[drive_addr[3:0]];
                    mem[drive_addr[3:0]] = '0;
                end
                sense <= (rc >= 12 && rc < 20) ? held : '1;
                rc++;
            end else begin
                rc = 0;
                sense <= '0;
            end
            if (wr_drive) mem[drive_addr[3:0]] = mem[drive_addr[3:0]] | ~inhibit;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one request and check its whole cycle; inj drives a stray request in cycle 40.
    task automatic run_op(input bit wr, input logic [3:0] a, input logic [15:0] d, input bit inj);
        int k_ack = 0, acks = 0, e_busy = 0, e_phase = 0, e_stb = 0, e_inh = 0, e_addr = 0;
        logic [15:0] rd_at_ack = '0;
        bit rdv_at_ack = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {AHI, a}; req_wdata = wr ? d : 16'h3C3C;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = 16'h0;
        for (int k = 1; k <= 400; k++) begin
            if (k > 1) @(negedge clk);
            if (inj && k == 40) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = {AHI, a}; req_wdata = 16'h0;
            end
            if (inj && k == 41) req_valid = 1'b0;
            if (!busy) e_busy++;
            if (rd_drive != (k >= 5 && k <= 84)) e_phase++;
            if (wr_drive != (k >= 93 && k <= 172)) e_phase++;
            if (inh_en != (k >= 1 && k <= 172)) e_phase++;
            if (addr_en != (rd_drive || wr_drive)) e_addr++;
            if (drive_addr != (addr_en ? {AHI, a} : 15'h0)) e_addr++;
            if (strobe != (k >= 17 && k <= 24)) e_stb++;
            if (inhibit != (wr_drive ? ~d : 16'h0)) e_inh++;
            if (ack) begin
                acks++; k_ack = k; rd_at_ack = rdata; rdv_at_ack = rdata_valid;
                break;
            end
        end
        chk(k_ack == 173, "R2 ack cycle", k_ack, 173);
        chk(e_phase == 0, "R2/R8 phase shape errors", e_phase, 0);
        chk(e_stb == 0, "R3 strobe window errors", e_stb, 0);
        chk(e_inh == 0, "R7 inhibit errors", e_inh, 0);
        chk(e_addr == 0, "R9 addr enable errors", e_addr, 0);
        chk(e_busy == 0, "R10 busy drop count", e_busy, 0);
        chk(rdv_at_ack == !wr, "R11 rdata_valid", rdv_at_ack, !wr);
        if (!wr) chk(rd_at_ack == d, "R5 read data", rd_at_ack, d);
        @(negedge clk);
        chk(!ack && !busy, "R11 ack single / R10 idle after", {ack, busy}, 0);
        if (inj) begin
            repeat (3) begin
                @(negedge clk);
                chk(!busy, "R10 stray request ignored", busy, 0);
            end
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk({busy, ack, rdata_valid, addr_en, rd_drive, wr_drive, strobe, inh_en} == 8'h0,
            "R1 reset controls", {busy, ack, rdata_valid, addr_en, rd_drive, wr_drive, strobe, inh_en}, 0);
        chk(inhibit == 0 && drive_addr == 0, "R1 reset lines", {inhibit, drive_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Table: writes check R6 through later reads, reads check R4/R5.
        for (int i = 0; i < 10; i++) begin
            run_op(VEC[i][20], VEC[i][19:16], VEC[i][15:0], 1'b0);
        end
        // R6: the host word overwrote a word of all ones.
        run_op(1'b1, 4'd2, 16'h00F0, 1'b0);
        run_op(1'b0, 4'd2, 16'h00F0, 1'b0);
        // R10: stray write request mid-cycle; the word must be unchanged afterwards.
        run_op(1'b0, 4'd1, 16'h0000, 1'b0);
        run_op(1'b0, 4'd3, 16'h0001, 1'b1);
        run_op(1'b0, 4'd3, 16'h0001, 1'b0);
        // R1: reset during a read pulse drops everything.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = {AHI, 4'd5};
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk(rd_drive, "R2 read pulse running before reset", rd_drive, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, rd_drive, wr_drive, strobe, inh_en, addr_en} == 6'h0,
            "R1 mid-cycle reset", {busy, rd_drive, wr_drive, strobe, inh_en, addr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 4'd2, 16'h00F0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule